// File: doc/BRIEF.md
# Transport Stream PID Filter

This block watches a byte-serial MPEG-2 transport stream, one byte per clock at most, with a marker on the first byte of every 188-byte packet. It keeps the packets whose packet identifier equals a programmable target and passes on only their payload bytes. Packets that are misframed or flagged as corrupted are dropped whole. Misframed packets are also counted.

For a downstream section assembler, the block handles the optional adaptation field and the pointer field itself. It strobes the forwarded byte at which a new section begins. It marks the final byte of each packet, and it holds a sticky flag once the continuity counter of the target stream skips.

Output is one registered byte stream with no backpressure. Each kept byte appears on the clock after it was taken in.

Top module: `ts_pid_filter`

## Requirements
- R1: A byte presented with `in_start_i` high is header byte 0 and must equal 0x47. If it does not, no byte of that packet is forwarded, and `sync_err_cnt_o` increases by one. The count saturates at its maximum.
- R2: Header byte 1 holds the corrupted flag in bit 7, the unit-start flag in bit 6, an ignored priority bit in bit 5, and PID[12:8] in bits 4:0. Header byte 2 is PID[7:0]. Only packets whose PID equals `target_pid_i` produce output.
- R3: A packet with the corrupted flag set forwards no byte.
- R4: Bits 5:4 of header byte 3 select the layout, and bit 4 means a payload is present. Value 01 means payload from byte 4. Value 11 means byte 4 holds a length L and payload starts at byte 5+L. Values 00 and 10 forward nothing.
- R5: When the unit-start flag is set, the first payload byte is a pointer P and is not forwarded. `out_start_o` is high on the forwarded byte whose packet position is P+1 past the pointer byte. There is no strobe if that position is beyond byte 187.
- R6: `out_last_o` is high on a forwarded byte only when it is packet byte 187.
- R7: Each forwarded byte equals the input byte, appears one clock after it is accepted, and arrives in input order. Header bytes never appear. `out_start_o` and `out_last_o` are high only together with `out_valid_o`.
- R8: Bits 3:0 of header byte 3 are the continuity counter. It is checked on target packets that carry a payload and have the corrupted flag clear. The first such packet after reset sets the reference. After that, any value other than previous+1 (mod 16) sets `cc_err_o`, which stays high until reset.
- R9: After reset, `out_valid_o`, `out_start_o`, `out_last_o`, `cc_err_o` and `sync_err_cnt_o` are all zero.
- R10: Bytes that arrive after byte 187 and before the next start marker are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| target_pid_i | input | 13 | PID to forward |
| in_valid_i | input | 1 | Input byte valid |
| in_start_i | input | 1 | Marks byte 0 of a packet |
| in_data_i | input | 8 | Input byte |
| out_valid_o | output | 1 | Output byte valid |
| out_data_o | output | 8 | Forwarded payload byte |
| out_start_o | output | 1 | First byte of a new section |
| out_last_o | output | 1 | Byte is the last of its packet |
| cc_err_o | output | 1 | Sticky continuity error |
| sync_err_cnt_o | output | CNT_W | Count of misframed packets |

## Verification
The assertions assume that `target_pid_i` stays stable while a packet is in flight. They also assume that `in_start_i` is only ever raised together with `in_valid_i`. The bench meets both assumptions: it sets the target once, before any traffic, and it raises the start marker only on the first driven byte of each packet. The stimulus also walks the edge layouts, such as an adaptation field that leaves one payload byte, pointers that land on the last byte or past it, and stray bytes after a packet, all inside those assumptions.

// File: rtl/ts_pkg.sv
`timescale 1ns/1ps
package ts_pkg;
  localparam int unsigned PKT_LEN   = 188;
  localparam logic [7:0]  SYNC_BYTE = 8'h47;
  localparam int unsigned HDR_PID_W = 13;
  // bit positions inside header bytes 1 and 3
  localparam int unsigned TEI_BIT   = 7;
  localparam int unsigned PUSI_BIT  = 6;
  localparam int unsigned ADAPT_BIT = 5;
  localparam int unsigned PAY_BIT   = 4;
endpackage

// File: rtl/ts_hdr_track.sv
`timescale 1ns/1ps
module ts_hdr_track
  import ts_pkg::*;
#(
  parameter int unsigned LEN   = PKT_LEN,
  parameter int unsigned CNT_W = 8,
  localparam int unsigned POS_W = $clog2(LEN + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_valid_i,
  input  logic                 in_start_i,
  input  logic [7:0]           in_data_i,
  output logic [POS_W-1:0]     pos_o,
  output logic                 live_o,
  output logic                 tei_o,
  output logic                 pusi_o,
  output logic [HDR_PID_W-1:0] pid_o,
  output logic [CNT_W-1:0]     sync_err_cnt_o
);
  logic [POS_W-1:0] idx_q;
  logic             active_q;

  assign pos_o  = idx_q;
  assign live_o = in_valid_i && !in_start_i && active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q          <= '0;
      active_q       <= 1'b0;
      sync_err_cnt_o <= '0;
    end else if (in_valid_i) begin
      if (in_start_i) begin
        idx_q    <= POS_W'(1);
        active_q <= (in_data_i == SYNC_BYTE);
        if (in_data_i != SYNC_BYTE && sync_err_cnt_o != '1)
          sync_err_cnt_o <= sync_err_cnt_o + 1'b1;
      end else if (active_q) begin
        if (idx_q == POS_W'(LEN - 1)) active_q <= 1'b0;
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tei_o  <= 1'b0;
      pusi_o <= 1'b0;
      pid_o  <= '0;
    end else if (live_o) begin
      if (idx_q == POS_W'(1)) begin
        tei_o              <= in_data_i[TEI_BIT];
        pusi_o             <= in_data_i[PUSI_BIT];
        pid_o[HDR_PID_W-1:8] <= in_data_i[HDR_PID_W-9:0];
      end
      if (idx_q == POS_W'(2)) pid_o[7:0] <= in_data_i;
    end
  end
endmodule

// File: rtl/ts_cc_check.sv
`timescale 1ns/1ps
module ts_cc_check #(
  parameter int unsigned CC_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            chk_i,
  input  logic [CC_W-1:0] cc_i,
  output logic            err_o
);
  logic [CC_W-1:0] prev_q;
  logic            have_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      have_q <= 1'b0;
      err_o  <= 1'b0;
    end else if (chk_i) begin
      prev_q <= cc_i;
      have_q <= 1'b1;
      if (have_q && cc_i != prev_q + 1'b1) err_o <= 1'b1;
    end
  end
endmodule

// File: rtl/ts_payload_gate.sv
`timescale 1ns/1ps
module ts_payload_gate
  import ts_pkg::*;
#(
  parameter int unsigned LEN = PKT_LEN,
  localparam int unsigned POS_W = $clog2(LEN + 1),
  localparam int unsigned PS_W  = POS_W + 1,
  localparam int unsigned SP_W  = POS_W + 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 live_i,
  input  logic [POS_W-1:0]     pos_i,
  input  logic [7:0]           data_i,
  input  logic                 tei_i,
  input  logic                 pusi_i,
  input  logic [HDR_PID_W-1:0] pid_i,
  input  logic [HDR_PID_W-1:0] target_pid_i,
  output logic                 hit_o,
  output logic                 valid_o,
  output logic [7:0]           data_o,
  output logic                 start_o,
  output logic                 last_o
);
  logic            keep_q, adapt_q;
  logic [PS_W-1:0] pay_start_q;
  logic [SP_W-1:0] sec_pos_q;
  logic [PS_W-1:0] pos_ps;
  logic [SP_W-1:0] pos_sp;
  logic            at_hdr3;

  assign pos_ps  = PS_W'(pos_i);
  assign pos_sp  = SP_W'(pos_i);
  assign at_hdr3 = live_i && pos_i == POS_W'(3);
  // decided on header byte 3: PID match, not corrupted, payload present
  assign hit_o   = at_hdr3 && !tei_i && pid_i == target_pid_i && data_i[PAY_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      keep_q      <= 1'b0;
      adapt_q     <= 1'b0;
      pay_start_q <= '1;
      sec_pos_q   <= '1;
      valid_o     <= 1'b0;
      data_o      <= '0;
      start_o     <= 1'b0;
      last_o      <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      start_o <= 1'b0;
      last_o  <= 1'b0;
      if (at_hdr3) begin
        keep_q      <= hit_o;
        adapt_q     <= data_i[ADAPT_BIT];
        pay_start_q <= data_i[ADAPT_BIT] ? '1 : PS_W'(4);
      end
      if (live_i && pos_i == POS_W'(4) && adapt_q)
        pay_start_q <= PS_W'(5) + PS_W'(data_i);
      if (live_i && keep_q && pos_ps >= pay_start_q) begin
        if (pusi_i && pos_ps == pay_start_q) begin
          sec_pos_q <= pos_sp + SP_W'(1) + SP_W'(data_i);
        end else begin
          valid_o <= 1'b1;
          data_o  <= data_i;
          start_o <= pusi_i && pos_sp == sec_pos_q;
          last_o  <= pos_i == POS_W'(LEN - 1);
        end
      end
    end
  end
endmodule

// File: rtl/ts_pid_filter.sv
`timescale 1ns/1ps
module ts_pid_filter
  import ts_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [HDR_PID_W-1:0] target_pid_i,
  input  logic                 in_valid_i,
  input  logic                 in_start_i,
  input  logic [7:0]           in_data_i,
  output logic                 out_valid_o,
  output logic [7:0]           out_data_o,
  output logic                 out_start_o,
  output logic                 out_last_o,
  output logic                 cc_err_o,
  output logic [CNT_W-1:0]     sync_err_cnt_o
);
  localparam int unsigned POS_W = $clog2(PKT_LEN + 1);

  logic [POS_W-1:0]     pos;
  logic                 live, tei, pusi, hit;
  logic [HDR_PID_W-1:0] pid;

  ts_hdr_track #(.LEN(PKT_LEN), .CNT_W(CNT_W)) u_hdr (
    .clk_i, .rst_ni, .in_valid_i, .in_start_i, .in_data_i,
    .pos_o(pos), .live_o(live), .tei_o(tei), .pusi_o(pusi), .pid_o(pid),
    .sync_err_cnt_o
  );

  ts_payload_gate #(.LEN(PKT_LEN)) u_gate (
    .clk_i, .rst_ni, .live_i(live), .pos_i(pos), .data_i(in_data_i),
    .tei_i(tei), .pusi_i(pusi), .pid_i(pid), .target_pid_i,
    .hit_o(hit), .valid_o(out_valid_o), .data_o(out_data_o),
    .start_o(out_start_o), .last_o(out_last_o)
  );

  ts_cc_check #(.CC_W(4)) u_cc (
    .clk_i, .rst_ni, .chk_i(hit), .cc_i(in_data_i[3:0]), .err_o(cc_err_o)
  );
endmodule

// File: rtl/ts_pid_filter_chk.sv
`timescale 1ns/1ps
module ts_pid_filter_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_start_i,
  input logic             out_valid_o,
  input logic             out_start_o,
  input logic             out_last_o,
  input logic             cc_err_o,
  input logic [CNT_W-1:0] sync_err_cnt_o
);
  // R7
  start_has_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_start_o |-> out_valid_o);
  // R7
  last_has_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> out_valid_o);
  // R7
  no_idle_output_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);
  // R7
  hdr_not_forwarded_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_start_i) |=> !out_valid_o);
  // R8
  cc_err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cc_err_o |=> cc_err_o);
  // R1
  sync_cnt_monotone_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_err_cnt_o >= $past(sync_err_cnt_o));
  // R1
  sync_cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_valid_i && in_start_i) |=> $stable(sync_err_cnt_o));
endmodule

bind ts_pid_filter ts_pid_filter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i),
  .in_start_i(in_start_i), .out_valid_o(out_valid_o),
  .out_start_o(out_start_o), .out_last_o(out_last_o),
  .cc_err_o(cc_err_o), .sync_err_cnt_o(sync_err_cnt_o)
);

// File: tb/ts_pid_filter_tb.sv
`timescale 1ns/1ps
module ts_pid_filter_tb;
  localparam logic [12:0] TGT = 13'h077;
  localparam int NONE = 255;

  typedef struct packed {
    logic        sync_ok;
    logic        tei;
    logic        pusi;
    logic [1:0]  afc;
    logic [7:0]  alen;
    logic [7:0]  ptr;
    logic [3:0]  cc;
    logic [12:0] pid;
    logic [7:0]  n_out;
    logic [7:0]  start_at;
    logic [7:0]  first_pos;
    logic        cc_err;
  } vec_t;

  // sync tei pusi afc alen ptr cc pid | n_out start_at first_pos cc_err
  localparam vec_t VEC [13] = '{
    '{1'b1,1'b0,1'b0,2'b01,8'd0,  8'd0,  4'd0, TGT,     8'd184,8'd255,8'd4,  1'b0}, // R4 plain
    '{1'b1,1'b0,1'b1,2'b01,8'd0,  8'd0,  4'd1, TGT,     8'd183,8'd0,  8'd5,  1'b0}, // R5 ptr 0
    '{1'b1,1'b0,1'b1,2'b11,8'd7,  8'd10, 4'd2, TGT,     8'd175,8'd10, 8'd13, 1'b0}, // R4 R5 adapt
    '{1'b1,1'b0,1'b0,2'b01,8'd0,  8'd0,  4'd9, 13'h100, 8'd0,  8'd255,8'd0,  1'b0}, // R2 other pid
    '{1'b1,1'b1,1'b0,2'b01,8'd0,  8'd0,  4'd7, TGT,     8'd0,  8'd255,8'd0,  1'b0}, // R3 corrupted
    '{1'b0,1'b0,1'b0,2'b01,8'd0,  8'd0,  4'd3, TGT,     8'd0,  8'd255,8'd0,  1'b0}, // R1 bad sync
    '{1'b1,1'b0,1'b0,2'b10,8'd183,8'd0,  4'd3, TGT,     8'd0,  8'd255,8'd0,  1'b0}, // R4 adapt only
    '{1'b1,1'b0,1'b0,2'b00,8'd0,  8'd0,  4'd3, TGT,     8'd0,  8'd255,8'd0,  1'b0}, // R4 reserved
    '{1'b1,1'b0,1'b1,2'b01,8'd0,  8'd200,4'd3, TGT,     8'd183,8'd255,8'd5,  1'b0}, // R5 ptr beyond
    '{1'b1,1'b0,1'b0,2'b11,8'd182,8'd0,  4'd4, TGT,     8'd1,  8'd255,8'd187,1'b0}, // R4 R6 one byte
    '{1'b1,1'b0,1'b1,2'b01,8'd0,  8'd182,4'd5, TGT,     8'd183,8'd182,8'd5,  1'b0}, // R5 ptr at end
    '{1'b1,1'b0,1'b0,2'b01,8'd0,  8'd0,  4'd9, TGT,     8'd184,8'd255,8'd4,  1'b1}, // R8 skip
    '{1'b1,1'b0,1'b0,2'b01,8'd0,  8'd0,  4'd10,TGT,     8'd184,8'd255,8'd4,  1'b1}  // R8 sticky
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_start = 1'b0;
  logic [7:0]  in_data = '0;
  logic        out_valid, out_start, out_last, cc_err;
  logic [7:0]  out_data;
  logic [7:0]  sync_cnt;

  int errors = 0, checks = 0;
  int mon_cnt, mon_start, mon_nstart, mon_last, mon_derr, exp_first;

  always #10 clk = ~clk;

  ts_pid_filter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .target_pid_i(TGT),
    .in_valid_i(in_valid), .in_start_i(in_start), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_start_o(out_start),
    .out_last_o(out_last), .cc_err_o(cc_err), .sync_err_cnt_o(sync_cnt)
  );

  function automatic logic [7:0] pat(input int p);
    return 8'(p) ^ 8'hA5;
  endfunction

  always @(negedge clk) begin
    if (out_valid) begin
      if (out_data != pat(exp_first + mon_cnt)) mon_derr++;
      if (out_start) begin mon_start = mon_cnt; mon_nstart++; end
      if (out_last) mon_last = mon_cnt;
      mon_cnt++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon(input int first);
    mon_cnt = 0; mon_start = NONE; mon_nstart = 0; mon_last = NONE;
    mon_derr = 0; exp_first = first;
  endtask

  task automatic send(input vec_t v, input int strays);
    int ps;
    ps = v.afc[1] ? 5 + int'(v.alen) : 4;
    for (int p = 0; p < 188 + strays; p++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_start = (p == 0);
      if (p == 0)      in_data = v.sync_ok ? 8'h47 : 8'h46;
      else if (p == 1) in_data = {v.tei, v.pusi, 1'b0, v.pid[12:8]};
      else if (p == 2) in_data = v.pid[7:0];
      else if (p == 3) in_data = {2'b00, v.afc, v.cc};
      else if (p == 4 && v.afc[1]) in_data = v.alen;
      else if (v.pusi && p == ps)  in_data = v.ptr;
      else             in_data = pat(p);
    end
    @(negedge clk);
    in_valid = 1'b0; in_start = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic check_pkt(input vec_t v, input string tag);
    check(mon_cnt == int'(v.n_out), {tag, " count"}, mon_cnt, v.n_out);
    check(mon_derr == 0, "R7 data/order", mon_derr, 0);
    check(mon_start == int'(v.start_at) && mon_nstart == (v.start_at == NONE ? 0 : 1),
          "R5 section start", mon_start, v.start_at);
    check(mon_last == (v.n_out == 0 ? NONE : int'(v.n_out) - 1), "R6 last flag",
          mon_last, v.n_out == 0 ? NONE : int'(v.n_out) - 1);
    check(cc_err == v.cc_err, "R8 cc error", cc_err, v.cc_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    clear_mon(0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9
    check(!out_valid && !out_start && !out_last, "R9 outputs idle", out_valid, 0);
    check(cc_err == 1'b0, "R9 cc flag", cc_err, 0);
    check(sync_cnt == 8'd0, "R9 sync count", sync_cnt, 0);

    for (int i = 0; i < 13; i++) begin
      clear_mon(int'(VEC[i].first_pos));
      send(VEC[i], 0);
      check_pkt(VEC[i], $sformatf("R2 R3 R4 vec%0d", i));
    end
    // R1
    check(sync_cnt == 8'd1, "R1 sync count", sync_cnt, 1);

    // R9: reset clears sticky state
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(cc_err == 1'b0, "R9 cc cleared", cc_err, 0);
    check(sync_cnt == 8'd0, "R9 count cleared", sync_cnt, 0);

    // R10: stray bytes after byte 187 are ignored
    clear_mon(4);
    send(VEC[0], 20);
    check(mon_cnt == 184, "R10 stray bytes", mon_cnt, 184);
    check(mon_last == 183, "R10 last position", mon_last, 183);
    check(mon_derr == 0, "R10 data", mon_derr, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule